// File: doc/BRIEF.md
# Network Status LED Driver

This block drives the status lamps of a 10 Mb/s Ethernet controller. It has a bank of `N_LED` programmable LEDs. Each one has its own configuration register that chooses which sources may light it: receive activity, a pulse that reports a received wake-up (magic) packet, and a full-duplex link indication. Each LED shows the logical OR of the sources it enables. An optional per-LED pulse stretcher holds the lamp on long enough for the eye to catch a one-cycle event. A dedicated link LED follows the twisted-pair link-pass signal. It is blanked in one duplex situation, so that a card with both a half-duplex and a full-duplex link lamp never lights both.

The full-duplex link source depends on the active port. On twisted pair it requires link pass and the full-duplex enable. On AUI it requires the full-duplex enable and the AUI full-duplex bit. On GPSI it requires only the full-duplex enable. Software programs and reads the configuration through a plain register port. A write takes effect at the next clock edge. A read is combinational. The readback also carries two read-only bits: the live, unstretched combined value of the addressed LED and the state of the link LED. The port has no back-pressure. A write is accepted in every cycle in which `cfg_wr` is high, and no data stream passes through the block.

Top module: `net_led_driver`

## Requirements
- R1: While reset is asserted and after it is released, every enable bit reads zero and all LED outputs are low, until a new configuration is written.
- R2: The value of a programmable LED is the OR of its enabled sources. Configuration bit 0 enables receive activity, bit 1 enables the magic-packet source and bit 2 enables the full-duplex link source. A source whose enable is clear has no effect.
- R3: The full-duplex link source depends on `port_sel`. Code 2'b00 selects twisted pair, and the source is link_pass AND fd_enable. Code 2'b01 selects AUI, and the source is fd_enable AND aui_fd. Code 2'b10 selects GPSI, and the source is fd_enable. Code 2'b11 gives zero.
- R4: With bit 1 set, a high `magic_pkt` lights the LED.
- R5: With stretch enable (bit 3) set, a single-cycle event keeps the LED high for exactly 2^STRETCH_LOG2 clock cycles. That is 8 cycles at the default.
- R6: An enabled event that arrives during a stretch restarts the full stretch period from that event.
- R7: With stretch disabled, `led_out` equals the combined value registered one clock edge earlier.
- R8: Readback bit 7 holds the live, unstretched combined value of the addressed LED in the same cycle. It is low during a stretch tail.
- R9: `link_led` is `link_pass` registered one edge earlier. It is forced low when all of these hold: port_sel is 2'b00, fd_enable is 1, aui_fd is 0, and bit 2 is set in any LED's register. Readback bit 6 shows `link_led`.
- R10: Configuration bits 4, 5, 6 and 7 are ignored on write. Bits 4 and 5 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_activity | input | 1 | Receive activity event |
| magic_pkt | input | 1 | Magic packet received pulse |
| link_pass | input | 1 | Twisted-pair link test reports pass |
| port_sel | input | 2 | Active port: 00 twisted pair, 01 AUI, 10 GPSI |
| fd_enable | input | 1 | Full-duplex enable configuration |
| aui_fd | input | 1 | AUI full-duplex configuration |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | LED register select |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Readback: {live, link, 00, stretch, fdl, mp, rcv} |
| led_out | output | N_LED | Programmable LED outputs, active high |
| link_led | output | 1 | Link status LED, active high |

## Verification
The hardest state to reach from the ports is the masked link LED. Link pass must be high while twisted pair is the active port, fd_enable is set, aui_fd is clear, and a full-duplex-link enable sits in the register of some LED. The bench sweeps every combination of the three non-stretch enables with every input pattern. It uses a second register whose bits are derived from the first, so the "any LED" term is reached through both registers. The stretch timing is reached with directed single-cycle pulses. One of these pulses lands a retrigger in the middle of a stretch tail.

// File: rtl/led_pkg.sv
package led_pkg;

  localparam int CFG_W = 8;

  localparam int BIT_LIVE = 7;
  localparam int BIT_LINK = 6;

  typedef enum logic [1:0] {
    PORT_TP   = 2'b00,
    PORT_AUI  = 2'b01,
    PORT_GPSI = 2'b10,
    PORT_NONE = 2'b11
  } port_e;

  typedef struct packed {
    logic stretch_en;
    logic fdl_en;
    logic mp_en;
    logic rcv_en;
  } led_cfg_t;

  localparam int FIELD_W = $bits(led_cfg_t);

endpackage

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
  import led_pkg::*;
#(
  parameter int N_LED = 2,
  parameter int AW    = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [CFG_W-1:0]        wdata,
  output led_cfg_t [N_LED-1:0]    cfg_q,
  output logic                    any_fdl
);

  for (genvar g = 0; g < N_LED; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (wr && (int'(addr) == g)) begin
        cfg_q[g] <= led_cfg_t'(wdata[FIELD_W-1:0]);
      end
    end
  end

  always_comb begin
    any_fdl = 1'b0;
    for (int i = 0; i < N_LED; i++) begin
      any_fdl = any_fdl | cfg_q[i].fdl_en;
    end
  end

endmodule

// File: rtl/led_fd_source.sv
module led_fd_source
  import led_pkg::*;
(
  input  port_e port_sel,
  input  logic  link_pass,
  input  logic  fd_enable,
  input  logic  aui_fd,
  output logic  fd_src
);

  always_comb begin
    unique case (port_sel)
      PORT_TP:   fd_src = link_pass & fd_enable;
      PORT_AUI:  fd_src = fd_enable & aui_fd;
      PORT_GPSI: fd_src = fd_enable;
      default:   fd_src = 1'b0;
    endcase
  end

endmodule

// File: rtl/led_channel.sv
module led_channel
  import led_pkg::*;
#(
  parameter int STRETCH_LOG2 = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  led_cfg_t cfg,
  input  logic     rx_activity,
  input  logic     magic_pkt,
  input  logic     fd_src,
  output logic     live,
  output logic     led_q
);

  logic [STRETCH_LOG2-1:0] cnt_q;
  logic                    tail;
  logic                    led_d;

  assign live = (cfg.rcv_en & rx_activity)
              | (cfg.mp_en  & magic_pkt)
              | (cfg.fdl_en & fd_src);

  assign tail  = (cnt_q != '0);
  assign led_d = cfg.stretch_en ? (live | tail) : live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      led_q <= 1'b0;
    end else begin
      led_q <= led_d;
      if (live && cfg.stretch_en) begin
        cnt_q <= '1;
      end else if (tail) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/led_link_mask.sv
module led_link_mask
  import led_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  link_pass,
  input  port_e port_sel,
  input  logic  fd_enable,
  input  logic  aui_fd,
  input  logic  any_fdl,
  output logic  link_q
);

  logic blank;

  assign blank = (port_sel == PORT_TP) & fd_enable & ~aui_fd & any_fdl;

  always_ff @(posedge clk) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_pass & ~blank;
  end

endmodule

// File: rtl/net_led_driver.sv
module net_led_driver
  import led_pkg::*;
#(
  parameter int N_LED        = 2,
  parameter int STRETCH_LOG2 = 3,
  localparam int AW          = (N_LED > 1) ? $clog2(N_LED) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_activity,
  input  logic             magic_pkt,
  input  logic             link_pass,
  input  logic [1:0]       port_sel,
  input  logic             fd_enable,
  input  logic             aui_fd,
  input  logic             cfg_wr,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  output logic [N_LED-1:0] led_out,
  output logic             link_led
);

  led_cfg_t [N_LED-1:0] cfg_q;
  logic                 any_fdl;
  logic                 fd_src;
  logic [N_LED-1:0]     live_w;
  port_e                port_w;

  assign port_w = port_e'(port_sel);

  led_cfg_regs #(.N_LED(N_LED), .AW(AW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .cfg_q  (cfg_q),
    .any_fdl(any_fdl)
  );

  led_fd_source u_fd (
    .port_sel (port_w),
    .link_pass(link_pass),
    .fd_enable(fd_enable),
    .aui_fd   (aui_fd),
    .fd_src   (fd_src)
  );

  for (genvar g = 0; g < N_LED; g++) begin : g_ch
    led_channel #(.STRETCH_LOG2(STRETCH_LOG2)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (cfg_q[g]),
      .rx_activity(rx_activity),
      .magic_pkt  (magic_pkt),
      .fd_src     (fd_src),
      .live       (live_w[g]),
      .led_q      (led_out[g])
    );
  end

  led_link_mask u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_pass(link_pass),
    .port_sel (port_w),
    .fd_enable(fd_enable),
    .aui_fd   (aui_fd),
    .any_fdl  (any_fdl),
    .link_q   (link_led)
  );

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[BIT_LINK] = link_led;
    for (int i = 0; i < N_LED; i++) begin
      if (int'(cfg_addr) == i) begin
        cfg_rdata[FIELD_W-1:0] = cfg_q[i];
        cfg_rdata[BIT_LIVE]    = live_w[i];
      end
    end
  end

endmodule

// File: rtl/net_led_checker.sv
module net_led_checker
  import led_pkg::*;
#(
  parameter int N_LED = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 magic_pkt,
  input logic                 link_pass,
  input logic [1:0]           port_sel,
  input logic                 fd_enable,
  input logic                 aui_fd,
  input logic [7:0]           cfg_rdata,
  input led_cfg_t [N_LED-1:0] cfg_q,
  input logic [N_LED-1:0]     live_w,
  input logic [N_LED-1:0]     led_out,
  input logic                 link_led
);

  logic any_fdl_c;
  always_comb begin
    any_fdl_c = 1'b0;
    for (int i = 0; i < N_LED; i++) any_fdl_c = any_fdl_c | cfg_q[i].fdl_en;
  end

  logic blank_c;
  assign blank_c = (port_sel == 2'b00) && fd_enable && !aui_fd && any_fdl_c;

  p_link_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blank_c |=> !link_led);

  p_link_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_pass && !blank_c) |=> link_led);

  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[5:4] == 2'b00);

  for (genvar g = 0; g < N_LED; g++) begin : g_chk
    p_event_lights_r2: assert property (@(posedge clk) disable iff (!rst_n)
      live_w[g] |=> led_out[g]);

    p_plain_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[g].stretch_en |=> (led_out[g] == $past(live_w[g])));

    p_magic_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (magic_pkt && cfg_q[g].mp_en) |-> live_w[g]);

    p_gpsi_fd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (port_sel == 2'b10 && fd_enable && cfg_q[g].fdl_en) |-> live_w[g]);
  end

endmodule

bind net_led_driver net_led_checker #(.N_LED(N_LED)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .magic_pkt(magic_pkt),
  .link_pass(link_pass),
  .port_sel (port_sel),
  .fd_enable(fd_enable),
  .aui_fd   (aui_fd),
  .cfg_rdata(cfg_rdata),
  .cfg_q    (cfg_q),
  .live_w   (live_w),
  .led_out  (led_out),
  .link_led (link_led)
);

// File: tb/test_net_led_driver.sv
`timescale 1ns/1ps
module test_net_led_driver;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_activity = 0, magic_pkt = 0, link_pass = 0;
  logic [1:0] port_sel = 0;
  logic       fd_enable = 0, aui_fd = 0;
  logic       cfg_wr = 0;
  logic [0:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic [7:0] cfg_rdata;
  logic [1:0] led_out;
  logic       link_led;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  net_led_driver i_net_led_driver (
    .clk(clk), .rst_n(rst_n), .rx_activity(rx_activity), .magic_pkt(magic_pkt),
    .link_pass(link_pass), .port_sel(port_sel), .fd_enable(fd_enable),
    .aui_fd(aui_fd), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .led_out(led_out), .link_led(link_led)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit fd_src(input logic [1:0] p, input bit lk, input bit fd, input bit au);
    case (p)
      2'b00:   return lk & fd;
      2'b01:   return fd & au;
      2'b10:   return fd;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit comb(input logic [2:0] c, input bit rx, input bit mp, input bit fs);
    return (c[0] & rx) | (c[1] & mp) | (c[2] & fs);
  endfunction

  task automatic write_cfg(input bit a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic read_bit(input bit a, input int b, output bit v);
    cfg_addr = a; #0.5; v = cfg_rdata[b];
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit v;
    // R1: state during reset with every input high
    rx_activity = 1; magic_pkt = 1; link_pass = 1; fd_enable = 1; port_sel = 2'b10;
    repeat (3) @(negedge clk);
    chk(led_out == 0, "R1 led in reset", led_out, 0);
    chk(link_led == 0, "R1 link in reset", link_led, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    cfg_addr = 0; #0.5;
    chk(cfg_rdata[3:0] == 0, "R1 enables0", cfg_rdata[3:0], 0);
    chk(led_out == 0, "R1 led after reset", led_out, 0);
    cfg_addr = 1; #0.5;
    chk(cfg_rdata[3:0] == 0, "R1 enables1", cfg_rdata[3:0], 0);

    // R2 R3 R4 R7 R8 R9: exhaustive sweep with stretch off
    for (int c = 0; c < 8; c++) begin
      for (int n = 0; n < 128; n++) begin
        logic [2:0] c0, c1;
        bit rx, mp, lk, fd, au, fs, e0, e1, el;
        logic [1:0] p;
        c0 = c[2:0]; c1 = {c0[0], c0[1], c0[2]};
        rx = n[0]; mp = n[1]; lk = n[2]; p = n[4:3]; fd = n[5]; au = n[6];
        @(negedge clk);
        rx_activity = rx; magic_pkt = mp; link_pass = lk; port_sel = p;
        fd_enable = fd; aui_fd = au;
        cfg_wr = 1; cfg_addr = 0; cfg_wdata = {5'b0, c0};
        @(negedge clk);
        cfg_addr = 1; cfg_wdata = {5'b0, c1};
        @(negedge clk);
        cfg_wr = 0;
        @(negedge clk);
        fs = fd_src(p, lk, fd, au);
        e0 = comb(c0, rx, mp, fs);
        e1 = comb(c1, rx, mp, fs);
        el = lk & ~((p == 2'b00) & fd & ~au & (c0[2] | c1[2]));
        chk(led_out[0] == e0, "R2 R3 R4 R7 led0", led_out[0], e0);
        chk(led_out[1] == e1, "R2 R3 R4 R7 led1", led_out[1], e1);
        chk(link_led == el, "R9 link led", link_led, el);
        read_bit(0, 7, v); chk(v == e0, "R8 live0", v, e0);
        read_bit(1, 7, v); chk(v == e1, "R8 live1", v, e1);
        read_bit(0, 6, v); chk(v == el, "R9 link readback", v, el);
      end
    end

    // R10: reserved and read-only bits ignored on write
    rx_activity = 0; magic_pkt = 0; link_pass = 0; fd_enable = 0; aui_fd = 0; port_sel = 2'b11;
    write_cfg(1, 8'h00);
    write_cfg(0, 8'hF1);
    cfg_addr = 0; #0.5;
    chk(cfg_rdata == 8'h01, "R10 readback", cfg_rdata, 8'h01);
    write_cfg(0, 8'h30);
    cfg_addr = 0; #0.5;
    chk(cfg_rdata == 8'h00, "R10 rsvd only", cfg_rdata, 0);
    @(negedge clk);
    chk(led_out == 0, "R10 no effect", led_out, 0);

    // R5: single-cycle event with stretch enabled (rcv + stretch = 8'h09)
    write_cfg(0, 8'h09);
    @(negedge clk); rx_activity = 1;
    @(negedge clk); rx_activity = 0;
    for (int k = 0; k < 8; k++) begin
      chk(led_out[0] == 1, "R5 stretch on", led_out[0], 1);
      if (k == 2) begin
        read_bit(0, 7, v); chk(v == 0, "R8 live in tail", v, 0);
      end
      @(negedge clk);
    end
    chk(led_out[0] == 0, "R5 stretch end", led_out[0], 0);
    chk(led_out[1] == 0, "R5 other led dark", led_out[1], 0);

    // R6: retrigger mid-stretch, magic packet source (mp + stretch = 8'h0A)
    write_cfg(0, 8'h0A);
    repeat (2) @(negedge clk);
    magic_pkt = 1;
    @(negedge clk); magic_pkt = 0;
    repeat (4) @(negedge clk);
    magic_pkt = 1;
    @(negedge clk); magic_pkt = 0;
    for (int k = 0; k < 8; k++) begin
      chk(led_out[0] == 1, "R6 restart on", led_out[0], 1);
      @(negedge clk);
    end
    chk(led_out[0] == 0, "R6 restart end", led_out[0], 0);

    // R7: stretch off, single-cycle event gives single-cycle LED
    write_cfg(0, 8'h01);
    @(negedge clk); rx_activity = 1;
    @(negedge clk); rx_activity = 0;
    chk(led_out[0] == 1, "R7 one cycle", led_out[0], 1);
    @(negedge clk);
    chk(led_out[0] == 0, "R7 drops", led_out[0], 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule